// File: doc/BRIEF.md
# Backplane Row Sequencer with Cascade Sync

This block steps through the backplane periods of a multiplexed LCD frame scan and says which display-memory row should feed the segment drivers in each period. It serves four drive modes: static (one backplane), and 1:2, 1:3 and 1:4 multiplex (two, three or four backplanes). The phase moves forward once per row period, and the period is marked by a single-cycle `row_tick` enable that comes from the frame-rate timing.

When several drivers are chained to make one larger display, they share an open-drain, active-low sync wire. A device pulls the wire low for the whole of its final backplane period and watches it the rest of the time. A device that sees the wire low while it is not pulling it takes that period to be the last one. The first device to pull low therefore brings the whole chain into step. In the two low-multiplex modes, a bank-select bit makes the block read a different part of memory, which lets software prepare one picture while another is on show. A blink setting divides the frame rate and blanks the segments for alternate half-periods.

Top module: `bp_row_seq`

## Requirements
- R1: Mode encoding is 0 static, 1 for 1:2, 2 for 1:3, 3 for 1:4, and the last row is equal to the mode value. On each `row_tick`, `bp_index` goes up by one, and after the last row it returns to 0.
- R2: When `row_tick` is low and no external sync is seen, `bp_index` holds its value.
- R3: `sync_pd` is high exactly while `bp_index` equals the last row of the current mode. In the multiplexed modes this means for one row period per frame; in static mode it is always high.
- R4: If `sync_n_in` is low while `sync_pd` is low, the current period counts as the last one. With no tick, `bp_index` becomes the mode's last row (3, 2 or 1) on the next clock. With a tick in the same cycle, `bp_index` becomes 0.
- R5: If `bp_index` is above the last row after a mode change, the next tick sets it to 0.
- R6: In static mode, `ram_row` is 0 when `bank_sel` is 0 and 2 when `bank_sel` is 1.
- R7: In 1:2 mode, `ram_row` equals `bp_index` when `bank_sel` is 0 and `bp_index`+2 when `bank_sel` is 1.
- R8: In 1:3 and 1:4 modes, `ram_row` equals `bp_index` and `bank_sel` has no effect.
- R9: When `blink_sel` is 0, `blank` stays low.
- R10: A frame is counted each time the index wraps to 0, whether from the last row or from an external sync. For `blink_sel` k from 1 to 3, `blank` is low for the first 2^(BLINK_LOG2+3-k) frames after reset, then high for the same number of frames, and so on. Rate 3 is the fastest.
- R11: After reset, `bp_index` is 0 and `blank` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_tick | input | 1 | One-cycle enable marking the end of a row period |
| mode | input | 2 | Drive mode: 0 static, 1 for 1:2, 2 for 1:3, 3 for 1:4 |
| bank_sel | input | 1 | Selects the alternate memory rows in static and 1:2 modes |
| blink_sel | input | 2 | 0 means no blinking, 1 to 3 are blink rates from slow to fast |
| sync_n_in | input | 1 | Level sensed on the shared active-low sync wire |
| sync_pd | output | 1 | Enable for the pull-down on the sync wire |
| bp_index | output | 2 | Active backplane index |
| ram_row | output | 2 | Display-memory row to read for the current period |
| blank | output | 1 | Forces all-off segment data during a blink off-half |

## Verification
The assertions check on every cycle that the index holds without a tick, steps by one before the last row, and jumps to the last row when an external sync arrives with no tick. They also check that the pull-down is released after the last period, that bank select never changes the row in 1:3 and 1:4 modes, that the frame counter advances once per wrap, and that blanking stays off while blinking is disabled. Other behaviour needs directed stimulus, so only the bench's scenarios show it: the full sequence in each mode, the start rows forced by sync, recovery after the mode is reduced, the row substitutions made by bank select, and the exact frame counts at which each blink rate toggles.

// File: rtl/bp_seq_pkg.sv
package bp_seq_pkg;

  typedef enum logic [1:0] {
    MUX_STATIC = 2'd0,
    MUX_DUO    = 2'd1,
    MUX_TRI    = 2'd2,
    MUX_QUAD   = 2'd3
  } mux_mode_e;

  // Last active backplane of a mode; equals the start row forced by sync.
  function automatic logic [1:0] last_row(input logic [1:0] mode);
    return mode;
  endfunction

  // Phase update for one clock.
  function automatic logic [1:0] next_phase(input logic [1:0] phase,
                                            input logic [1:0] last,
                                            input logic       tick,
                                            input logic       ext_sync);
    if (tick) begin
      if (ext_sync || (phase >= last)) return 2'd0;
      return phase + 2'd1;
    end
    if (ext_sync) return last;
    return phase;
  endfunction

  // Memory row read for a backplane phase, with bank substitution.
  function automatic logic [1:0] bank_row(input logic [1:0] mode,
                                          input logic [1:0] phase,
                                          input logic       bank);
    case (mode)
      MUX_STATIC: return bank ? 2'd2 : 2'd0;
      MUX_DUO:    return bank ? {1'b1, phase[0]} : phase;
      default:    return phase;
    endcase
  endfunction

  // Frame-counter bit that drives blanking for a blink rate (1..3).
  function automatic int unsigned blink_bit(input logic [1:0] sel,
                                            input int unsigned base);
    return base + 3 - int'(sel);
  endfunction

endpackage

// File: rtl/bp_phase_ctr.sv
module bp_phase_ctr
  import bp_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       row_tick,
  input  logic [1:0] mode,
  input  logic       sync_n_in,
  output logic [1:0] phase,
  output logic       sync_pd,
  output logic       ext_sync,
  output logic       frame_wrap
);

  logic [1:0] last;

  assign last       = last_row(mode);
  assign sync_pd    = (phase == last);
  assign ext_sync   = !sync_n_in && !sync_pd;
  assign frame_wrap = row_tick && (ext_sync || (phase >= last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= 2'd0;
    else        phase <= next_phase(phase, last, row_tick, ext_sync);
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_tick && !ext_sync) |=> $stable(phase));

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (row_tick && !ext_sync && (phase < last)) |=> (phase == $past(phase) + 2'd1));

  assert_sync_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sync && !row_tick) |=> (phase == $past(last)));

  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (phase == 2'd0));

endmodule

// File: rtl/bp_bank_map.sv
module bp_bank_map
  import bp_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic [1:0] phase,
  input  logic       bank_sel,
  output logic [1:0] ram_row
);

  assign ram_row = bank_row(mode, phase, bank_sel);

  assert_bank_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |-> (ram_row == phase));

  assert_duo_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MUX_DUO) && bank_sel) |-> ram_row[1]);

endmodule

// File: rtl/bp_blink_gate.sv
module bp_blink_gate
  import bp_seq_pkg::*;
#(
  parameter int unsigned BLINK_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_wrap,
  input  logic [1:0] blink_sel,
  output logic       blank
);

  localparam int unsigned CNT_W = BLINK_LOG2 + 3;
  localparam int unsigned IDX_W = $clog2(CNT_W);

  logic [CNT_W-1:0] frame_cnt;
  logic [IDX_W-1:0] sel_bit;

  assign sel_bit = IDX_W'(blink_bit(blink_sel, BLINK_LOG2));
  assign blank   = (blink_sel != 2'd0) && frame_cnt[sel_bit];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          frame_cnt <= '0;
    else if (frame_wrap) frame_cnt <= frame_cnt + 1'b1;
  end

  assert_frame_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (frame_cnt == $past(frame_cnt) + 1'b1));

  assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> $stable(frame_cnt));

  assert_blink_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (blink_sel == 2'd0) |-> !blank);

endmodule

// File: rtl/bp_row_seq.sv
module bp_row_seq
  import bp_seq_pkg::*;
#(
  parameter int unsigned BLINK_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       row_tick,
  input  logic [1:0] mode,
  input  logic       bank_sel,
  input  logic [1:0] blink_sel,
  input  logic       sync_n_in,
  output logic       sync_pd,
  output logic [1:0] bp_index,
  output logic [1:0] ram_row,
  output logic       blank
);

  logic ext_sync;
  logic frame_wrap;

  bp_phase_ctr u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .row_tick   (row_tick),
    .mode       (mode),
    .sync_n_in  (sync_n_in),
    .phase      (bp_index),
    .sync_pd    (sync_pd),
    .ext_sync   (ext_sync),
    .frame_wrap (frame_wrap)
  );

  bp_bank_map u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .phase    (bp_index),
    .bank_sel (bank_sel),
    .ram_row  (ram_row)
  );

  bp_blink_gate #(.BLINK_LOG2(BLINK_LOG2)) u_blink (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_wrap (frame_wrap),
    .blink_sel  (blink_sel),
    .blank      (blank)
  );

  // Pull-down lasts one row period in multiplexed modes.
  assert_pull_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pd && row_tick && (mode != 2'd0)) |=> (!sync_pd || (mode != $past(mode))));

endmodule

// File: tb/bp_row_seq_test.sv
module bp_row_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int LOG2 = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       row_tick = 1'b0;
  logic [1:0] mode = 2'd3;
  logic       bank_sel = 1'b0;
  logic [1:0] blink_sel = 2'd0;
  logic       sync_n_in = 1'b1;
  logic       sync_pd;
  logic [1:0] bp_index;
  logic [1:0] ram_row;
  logic       blank;

  int n_checks = 0;
  int n_fail = 0;

  bp_row_seq #(.BLINK_LOG2(LOG2)) uut (
    .clk(clk), .rst_n(rst_n), .row_tick(row_tick), .mode(mode),
    .bank_sel(bank_sel), .blink_sel(blink_sel), .sync_n_in(sync_n_in),
    .sync_pd(sync_pd), .bp_index(bp_index), .ram_row(ram_row), .blank(blank)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t);
    row_tick = t;
    @(posedge clk);
    #1;
    row_tick = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    row_tick = 1'b0;
    sync_n_in = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    mode = 2'd3; blink_sel = 2'd3;
    do_reset();
    chk("R11 bp_index", bp_index, 0);
    chk("R11 blank", blank, 0);
    chk("R3 no pull at reset in 1:4", sync_pd, 0);
    blink_sel = 2'd0;
  endtask

  task automatic t_cycle(input int m);
    mode = 2'(m);
    do_reset();
    for (int i = 1; i <= 2 * (m + 1); i++) begin
      cyc(1'b1);
      chk("R1 sequence", bp_index, i % (m + 1));
      chk("R3 pull on last", sync_pd, ((i % (m + 1)) == m) ? 1 : 0);
    end
  endtask

  task automatic t_hold();
    mode = 2'd3;
    do_reset();
    cyc(1'b1); cyc(1'b1);
    for (int i = 0; i < 3; i++) begin
      cyc(1'b0);
      chk("R2 hold", bp_index, 2);
    end
  endtask

  task automatic t_sync();
    for (int m = 3; m >= 1; m--) begin
      mode = 2'(m);
      do_reset();
      sync_n_in = 1'b0;
      cyc(1'b0);
      chk("R4 sync start row", bp_index, m);
      chk("R3 takes over pull", sync_pd, 1);
      sync_n_in = 1'b1;
      cyc(1'b1);
      chk("R4 after sync wrap", bp_index, 0);
    end
    mode = 2'd3;
    do_reset();
    cyc(1'b1);
    sync_n_in = 1'b0;
    cyc(1'b1);
    chk("R4 sync with tick", bp_index, 0);
    sync_n_in = 1'b1;
    mode = 2'd0;
    do_reset();
    sync_n_in = 1'b0;
    cyc(1'b0);
    chk("R4 static start row", bp_index, 0);
    sync_n_in = 1'b1;
  endtask

  task automatic t_shrink();
    mode = 2'd3;
    do_reset();
    cyc(1'b1); cyc(1'b1); cyc(1'b1);
    chk("R1 reach row 3", bp_index, 3);
    mode = 2'd1;
    cyc(1'b1);
    chk("R5 shrink wrap", bp_index, 0);
    cyc(1'b1);
    chk("R5 continues in 1:2", bp_index, 1);
  endtask

  task automatic t_bank();
    mode = 2'd0;
    do_reset();
    bank_sel = 1'b1; #1;
    chk("R6 static bank 1", ram_row, 2);
    bank_sel = 1'b0; #1;
    chk("R6 static bank 0", ram_row, 0);
    mode = 2'd1;
    do_reset();
    bank_sel = 1'b1; #1;
    chk("R7 duo bank row a", ram_row, 2);
    cyc(1'b1);
    chk("R7 duo bank row b", ram_row, 3);
    bank_sel = 1'b0; #1;
    chk("R7 duo plain", ram_row, 1);
    for (int m = 2; m <= 3; m++) begin
      mode = 2'(m);
      do_reset();
      bank_sel = 1'b1;
      for (int i = 0; i <= m; i++) begin
        chk("R8 bank ignored", ram_row, bp_index);
        chk("R8 row value", ram_row, i);
        cyc(1'b1);
      end
    end
    bank_sel = 1'b0;
  endtask

  task automatic t_blink();
    mode = 2'd0;
    blink_sel = 2'd0;
    do_reset();
    for (int n = 0; n < 40; n++) begin
      cyc(1'b1);
      chk("R9 blink off", blank, 0);
    end
    for (int s = 1; s <= 3; s++) begin
      int b;
      b = LOG2 + 3 - s;
      blink_sel = 2'(s);
      do_reset();
      for (int n = 1; n <= (2 << b) + 2; n++) begin
        cyc(1'b1);
        chk("R10 blink static", blank, (n >> b) & 1);
      end
    end
    mode = 2'd3;
    blink_sel = 2'd3;
    do_reset();
    repeat (63) cyc(1'b1);
    chk("R10 frame 15", blank, 0);
    cyc(1'b1);
    chk("R10 frame 16", blank, 1);
    blink_sel = 2'd0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    for (int m = 0; m < 4; m++) t_cycle(m);
    t_hold();
    t_sync();
    t_shrink();
    t_bank();
    t_blink();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule